// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clocked Mode

This block turns bytes written by a host into a serial bit stream. A one-entry data register takes the host's byte and a separate shift register sends it, so the host can load the next byte while the current one is still going out. A `dr_empty` flag tells the host when the data register may be written again. A `sr_empty` flag tells it when every byte has fully left the block.

In framed mode a character is a low start bit, followed by 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit and one high stop bit. Every bit lasts one interval of the external `baud_tick` pulse. A byte waiting in the data register follows the previous stop bit with no idle time in between.

In clocked mode exactly 8 data bits are sent and there are no framing bits. The block drives its own serial clock. The data changes on that clock's falling edge, and the clock stays high between characters. Baud rate generation and the host bus decode live outside the block.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, and whenever no character is in progress and no byte is waiting, `tx_out` = 1, `sclk_out` = 1, `dr_empty` = 1 and `sr_empty` = 1.
- R2: A character starts only on a cycle with `baud_tick` = 1, `tx_en` = 1 and a byte held in the data register. `tx_out` changes only on the cycle after a `baud_tick`. In framed mode the first bit is a start bit of value 0, and every bit lasts exactly one baud tick interval.
- R3: Data bits are sent least significant bit first, starting with `wr_data[0]`.
- R4: In framed mode `char_len` selects the number of data bits: 00 selects 5, 01 selects 6, 10 selects 7 and 11 selects 8. Byte bits above the selected length are not sent.
- R5: In framed mode, `par_en` = 1 inserts one parity bit right after the last data bit. With `par_odd` = 0 the data bits and the parity bit together hold an even number of ones; with `par_odd` = 1 they hold an odd number. A single stop bit of value 1 ends every framed character.
- R6: `dr_empty` goes to 0 on the cycle after a host write (`wr_en` = 1). It goes back to 1 on the cycle after the byte moves into the shift register, which is the cycle on which the byte's first bit appears. A new write is accepted while the previous character is still being sent.
- R7: When a byte is waiting, the tick that ends the current character's last bit starts the next character at once, with no idle bit in between.
- R8: `sr_empty` is 1 only when no character is being shifted and the data register is empty.
- R9: With `sync_mode` = 1, exactly 8 data bits are sent per character, with no start, parity or stop bit, whatever the values of `char_len` and `par_en`.
- R10: In clocked mode each bit spans two baud ticks. `sclk_out` falls on the same cycle `tx_out` takes a new bit and rises at the next tick. `sclk_out` stays 1 in framed mode and between clocked characters.
- R11: While `tx_en` = 0 no new character starts and a written byte stays in the data register. A character already in progress runs to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Allows new characters to start |
| sync_mode | input | 1 | 1 = clocked 8-bit mode, 0 = framed mode |
| char_len | input | 2 | Framed data length code (5 + code bits) |
| par_en | input | 1 | Adds a parity bit in framed mode |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | 8 | Host byte |
| tx_out | output | 1 | Serial data output |
| sclk_out | output | 1 | Serial clock output for clocked mode |
| dr_empty | output | 1 | Data register can take another byte |
| sr_empty | output | 1 | Shift register and data register both empty |

## Verification
Framed characters are sent with random bytes, random lengths and random parity settings. These runs show whether the data goes out in the right order, whether bits above the selected length are cut off, and whether the parity sense is correct. Directed bytes of all ones and all zeros isolate truncation and odd parity. Back-to-back writes in both modes show whether the double buffer frees at the right time and whether the next character follows with no gap. A write made with the enable low shows that a held byte neither starts nor is lost. Clocked runs, with random length and parity settings left on the inputs, show that those settings are ignored and that the clock falls exactly when the data changes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic {
        MODE_FRAMED  = 1'b0,
        MODE_CLOCKED = 1'b1
    } tx_mode_e;

    // smallest framed length is DATA_W minus this offset
    localparam int LEN_OFFSET = 3;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (take)  d.full = 1'b0;
        // a write in the same cycle as a take refills the register
        if (wr_en) begin
            d.data = wr_data;
            d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_data = q.data;
    assign full      = q.full;

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [1:0]         len_code,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               clocked,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   flen
);

    int   nbits;
    logic par;

    always_comb begin
        nbits = DATA_W - sertx_pkg::LEN_OFFSET + int'(len_code);
        par   = par_odd;
        frame = '1;
        if (clocked) begin
            frame[DATA_W-1:0] = data;
            flen = CNT_W'(DATA_W);
        end else begin
            frame[0] = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (i < nbits) begin
                    frame[i+1] = data[i];
                    par        = par ^ data[i];
                end
            end
            for (int j = 0; j < FRAME_W; j++) begin
                if (par_en && (j == nbits + 1)) frame[j] = par;
            end
            flen = CNT_W'(nbits + 2 + (par_en ? 1 : 0));
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               tx_en,
    input  logic               sync_mode,
    input  logic               pending,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   flen,
    output logic               take,
    output logic               tx_out,
    output logic               sclk_out,
    output logic               busy,
    output logic               sync_act
);

    import sertx_pkg::*;

    typedef struct packed {
        logic               busy;
        tx_mode_e           mode;
        logic               phase;
        logic               sclk;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } shift_t;

    shift_t q, d;
    logic   start;
    logic   can_load;

    always_comb begin
        d        = q;
        start    = 1'b0;
        can_load = pending && tx_en;
        if (tick) begin
            if (!q.busy) begin
                start = can_load;
            end else if ((q.mode == MODE_CLOCKED) && !q.phase) begin
                d.phase = 1'b1;
                d.sclk  = 1'b1;
            end else if (q.cnt > CNT_W'(1)) begin
                d.sh    = {1'b1, q.sh[FRAME_W-1:1]};
                d.cnt   = q.cnt - 1'b1;
                d.phase = 1'b0;
                d.sclk  = (q.mode != MODE_CLOCKED);
            end else begin
                start = can_load;
                if (!can_load) begin
                    d.busy  = 1'b0;
                    d.sclk  = 1'b1;
                    d.phase = 1'b0;
                end
            end
        end
        if (start) begin
            d.busy  = 1'b1;
            d.mode  = sync_mode ? MODE_CLOCKED : MODE_FRAMED;
            d.phase = 1'b0;
            d.sclk  = !sync_mode;
            d.sh    = frame;
            d.cnt   = flen;
        end
        take = start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
            q.sh   <= '1;
        end else begin
            q <= d;
        end
    end

    assign tx_out   = q.busy ? q.sh[0] : 1'b1;
    assign sclk_out = q.sclk;
    assign busy     = q.busy;
    assign sync_act = (q.mode == MODE_CLOCKED);

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_out,
    output logic              sclk_out,
    output logic              dr_empty,
    output logic              sr_empty
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  hold_data;
    logic               full;
    logic               take;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   flen;
    logic               busy;
    logic               sync_act;

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .full      (full)
    );

    sertx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .data     (hold_data),
        .len_code (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .clocked  (sync_mode),
        .frame    (frame),
        .flen     (flen)
    );

    sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .tx_en     (tx_en),
        .sync_mode (sync_mode),
        .pending   (full),
        .frame     (frame),
        .flen      (flen),
        .take      (take),
        .tx_out    (tx_out),
        .sclk_out  (sclk_out),
        .busy      (busy),
        .sync_act  (sync_act)
    );

    assign dr_empty = !full;
    assign sr_empty = !full && !busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic baud_tick,
    input logic wr_en,
    input logic tx_out,
    input logic sclk_out,
    input logic dr_empty,
    input logic sr_empty,
    input logic busy,
    input logic sync_act
);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sr_empty |-> (tx_out && sclk_out));

    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(tx_en) && $past(baud_tick)));

    p_change_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out != $past(tx_out)) |-> $past(baud_tick));

    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !dr_empty);

    p_sclk_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_out != $past(sclk_out)) |-> $past(baud_tick));

    p_data_at_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sync_act && (tx_out != $past(tx_out))) |-> $fell(sclk_out));

    p_sclk_high_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || !sync_act) |-> sclk_out);

endmodule

bind dbuf_serial_tx sertx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .tx_out    (tx_out),
    .sclk_out  (sclk_out),
    .dr_empty  (dr_empty),
    .sr_empty  (sr_empty),
    .busy      (busy),
    .sync_act  (sync_act)
);

// File: tb/sim_dbuf_serial_tx.sv
module sim_dbuf_serial_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en;
    logic       sync_mode;
    logic [1:0] char_len;
    logic       par_en;
    logic       par_odd;
    logic       baud_tick;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       tx_out;
    logic       sclk_out;
    logic       dr_empty;
    logic       sr_empty;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dbuf_serial_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .sync_mode (sync_mode),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .baud_tick (baud_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_out    (tx_out),
        .sclk_out  (sclk_out),
        .dr_empty  (dr_empty),
        .sr_empty  (sr_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // framed bit list, index 0 goes out first
    function automatic logic [10:0] exp_frame(input logic [7:0] d, input int n,
                                              input bit pen, input bit podd);
        logic [10:0] f = '1;
        int k = 1;
        bit p = podd;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[k] = d[i];
            p    = p ^ d[i];
            k++;
        end
        if (pen) begin
            f[k] = p;
            k++;
        end
        f[k] = 1'b1;
        return f;
    endfunction

    function automatic int exp_len(input int n, input bit pen);
        return n + 2 + (pen ? 1 : 0);
    endfunction

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] cl, input bit pen, input bit podd, input bit sm);
        char_len  = cl;
        par_en    = pen;
        par_odd   = podd;
        sync_mode = sm;
    endtask

    // sends the remaining bits of a framed character whose first bit is already out
    task automatic rest_framed(input logic [10:0] f, input int len);
        for (int i = 1; i < len; i++) begin
            tick();
            chk($sformatf("R3/R4/R5 framed bit %0d", i), tx_out, f[i]);
        end
    endtask

    task automatic run_framed(input logic [7:0] d, input logic [1:0] cl, input bit pen, input bit podd);
        logic [10:0] f;
        int n;
        n = 5 + int'(cl);
        f = exp_frame(d, n, pen, podd);
        set_cfg(cl, pen, podd, 1'b0);
        host_write(d);
        chk("R6 dr_empty after write", dr_empty, 0);
        chk("R8 sr_empty with pending byte", sr_empty, 0);
        tick();
        chk("R2 start bit", tx_out, 0);
        chk("R6 dr_empty after transfer", dr_empty, 1);
        chk("R8 sr_empty while shifting", sr_empty, 0);
        rest_framed(f, exp_len(n, pen));
        tick();
        chk("R4 idle after last bit", tx_out, 1);
        chk("R1 sr_empty idle", sr_empty, 1);
    endtask

    task automatic clocked_bits(input logic [7:0] d);
        for (int b = 0; b < 8; b++) begin
            if (b > 0) tick();
            chk($sformatf("R9 clocked bit %0d", b), tx_out, d[b]);
            chk("R10 sclk low with new data", sclk_out, 0);
            tick();
            chk("R10 sclk rises next tick", sclk_out, 1);
            chk("R10 data stable over rise", tx_out, d[b]);
        end
    endtask

    task automatic run_clocked(input logic [7:0] d);
        set_cfg(2'($urandom_range(0, 3)), 1'b1, 1'($urandom_range(0, 1)), 1'b1);
        host_write(d);
        tick();
        clocked_bits(d);
        tick();
        chk("R9 no bit after eighth", tx_out, 1);
        chk("R10 sclk idles high", sclk_out, 1);
        chk("R1 sr_empty after clocked", sr_empty, 1);
    endtask

    initial begin
        logic [7:0] a, b;
        logic [10:0] fa, fb;
        void'($urandom(32'd1357));
        rst_n = 1'b0; tx_en = 1'b1; baud_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 reset tx_out", tx_out, 1);
        chk("R1 reset sclk_out", sclk_out, 1);
        chk("R1 reset dr_empty", dr_empty, 1);
        chk("R1 reset sr_empty", sr_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no start without a tick
        host_write(8'h3c);
        repeat (5) @(negedge clk);
        chk("R2 no start before tick", tx_out, 1);
        tick();
        chk("R2 start on tick", tx_out, 0);
        rest_framed(exp_frame(8'h3c, 8, 0, 0), 10);
        tick();

        // directed: truncation and odd parity on zero
        run_framed(8'hff, 2'd0, 1'b0, 1'b0);
        run_framed(8'h00, 2'd3, 1'b1, 1'b1);
        run_framed(8'he0, 2'd1, 1'b1, 1'b0);

        for (int r = 0; r < 20; r++)
            run_framed(8'($urandom), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R7: back-to-back framed
        a = 8'($urandom); b = 8'($urandom);
        set_cfg(2'd2, 1'b1, 1'b0, 1'b0);
        fa = exp_frame(a, 7, 1, 0); fb = exp_frame(b, 7, 1, 0);
        host_write(a);
        tick();
        host_write(b);
        chk("R6 second write accepted", dr_empty, 0);
        rest_framed(fa, 10);
        tick();
        chk("R7 next start with no gap", tx_out, 0);
        chk("R6 freed at second start", dr_empty, 1);
        rest_framed(fb, 10);
        tick();
        chk("R7 idle after pair", sr_empty, 1);

        // R11: disable during a character
        a = 8'h5a; b = 8'ha5;
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        host_write(a);
        tick();
        host_write(b);
        tx_en = 1'b0;
        rest_framed(exp_frame(a, 8, 0, 0), 10);
        tick();
        chk("R11 held byte not started", tx_out, 1);
        chk("R11 byte kept", dr_empty, 0);
        tick();
        chk("R11 still idle", tx_out, 1);
        tx_en = 1'b1;
        tick();
        chk("R11 starts after enable", tx_out, 0);
        rest_framed(exp_frame(b, 8, 0, 0), 10);
        tick();

        // clocked mode
        run_clocked(8'h01);
        run_clocked(8'h80);
        for (int r = 0; r < 6; r++) run_clocked(8'($urandom));

        // R7 in clocked mode
        a = 8'($urandom); b = 8'($urandom);
        set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
        host_write(a);
        tick();
        host_write(b);
        clocked_bits(a);
        tick();
        chk("R7 clocked next bit0", tx_out, b[0]);
        chk("R10 clocked next falls", sclk_out, 0);
        tick();
        chk("R10 clocked next rises", sclk_out, 1);
        for (int k = 1; k < 8; k++) begin
            tick();
            chk("R9 second clocked char", tx_out, b[k]);
            tick();
        end
        tick();
        chk("R10 clocked idle", sclk_out, 1);
        chk("R1 idle after clocked pair", sr_empty, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule